// File: doc/BRIEF.md
# Single-Word Fast Mailbox Bank

This block is a bank of eight independent one-way channels, each of which carries exactly one 32-bit word from a sending agent to a receiving agent. The sender writes a word into a channel's data register. In that same write the channel's pending flag is raised. The flag appears at a fixed bit in a shared status word. If the receiver has enabled that channel, the flag pulls the receiver interrupt high.

The receiver services a channel in two steps. It acknowledges the flag by writing a one to the matching bit of the clear register, and then it reads the word. The word stays in place until the sender writes that channel again. The sender side gets no completion interrupt. A sender that writes again before the receiver acknowledges simply replaces the word, and the flag stays raised.

The block is reached through a single register write port and a combinational read port. Both agents use these ports through the system interconnect. All addresses are byte addresses. Channel `i` owns status, clear and enable bit `9+i`.

Top module: `mbx_fast_top`

## Requirements
- R1: After reset, every data register, the status word and the enable word read 0, and `irq` is low.
- R2: A write to byte address 0x8C + 4·i (i = 0..7) stores `wr_data` as channel i's word, and the word reads back at that same address.
- R3: A write to channel i's data address sets status bit 9+i. The status word is read at 0xC8, and the bit is visible from the first clock edge after the write.
- R4: Writing the clear register at 0xC4 lowers every status bit 9..16 whose `wr_data` bit is 1. It leaves bits written as 0 unchanged, does not alter any stored word, and reads back as 0.
- R5: A second write to a channel whose flag is still set replaces the stored word, and status bit 9+i stays set.
- R6: The enable word at 0xC0 stores `wr_data` bits 9..16 and reads them back. All of its other bits read as 0.
- R7: `irq` is high exactly when some channel has both its status bit and its enable bit set. Disabled channels never raise it.
- R8: Writes to the status address 0xC8 or to any unmapped address change no register. Reads of unmapped addresses return 0.
- R9: A write to one channel changes only that channel's word and status bit. The other channels' words and bits are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Byte address of the read |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| irq | output | 1 | Receiver interrupt |

## Verification
Each piece of internal state reaches a port within one clock. A stored word, a pending flag or an enable bit that is wrong shows up at `rd_data` at the next read of its address, and it also shows up at `irq` from the edge after the write that went wrong. For that reason the bench reads back an address after every write, and it checks `irq` after every write. A decode fault that lets one channel's write touch a neighbour shows up as an unexpected word or status bit at another channel's address. A clear that hits the wrong bit shows up as a flag that stays high or drops out when it should not.

// File: rtl/mbx_fast_pkg.sv
package mbx_fast_pkg;
  localparam int AW        = 8;
  localparam int NUM_CH    = 8;
  localparam int WORD_W    = 32;
  localparam int FIRST_BIT = 9;
  localparam logic [AW-1:0] DATA_BASE = 8'h8C;
  localparam logic [AW-1:0] EN_ADDR   = 8'hC0;
  localparam logic [AW-1:0] CLR_ADDR  = 8'hC4;
  localparam logic [AW-1:0] STAT_ADDR = 8'hC8;

  // byte address of channel idx's data register
  function automatic logic [AW-1:0] chan_addr(input int idx);
    return DATA_BASE + AW'(4 * idx);
  endfunction

  // place per-channel bits at their fixed offset in a status-shaped word
  function automatic logic [WORD_W-1:0] spread_bits(input logic [NUM_CH-1:0] bits);
    logic [WORD_W-1:0] w;
    w = '0;
    w[FIRST_BIT +: NUM_CH] = bits;
    return w;
  endfunction
endpackage

// File: rtl/mbx_fast_decode.sv
module mbx_fast_decode
  import mbx_fast_pkg::*;
#(
  parameter int NCH = NUM_CH
) (
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  output logic [NCH-1:0] data_hit,
  output logic          en_hit,
  output logic          clr_hit,
  output logic          any_hit
);
  for (genvar g = 0; g < NCH; g++) begin : g_dec
    assign data_hit[g] = wr_en && (wr_addr == chan_addr(g));
  end
  assign en_hit  = wr_en && (wr_addr == EN_ADDR);
  assign clr_hit = wr_en && (wr_addr == CLR_ADDR);
  assign any_hit = (|data_hit) || en_hit || clr_hit;
endmodule

// File: rtl/mbx_fast_chan.sv
module mbx_fast_chan #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          ack,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] word,
  output logic          pending
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word    <= '0;
      pending <= 1'b0;
    end else begin
      if (load) word <= wdata;
      if (load)     pending <= 1'b1;
      else if (ack) pending <= 1'b0;
    end
  end

  // R3 / R5: a load always leaves the flag raised
  p_set_on_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> pending);
  // R4: an acknowledge without a load drops the flag
  p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !load) |=> !pending);
  // R5: the flag never drops on its own
  p_flag_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !ack) |=> pending);
  // R2: the stored word moves only on a load
  p_word_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(word));
endmodule

// File: rtl/mbx_fast_top.sv
module mbx_fast_top
  import mbx_fast_pkg::*;
#(
  parameter int NCH = NUM_CH,
  parameter int DW  = WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [7:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          irq
);
  localparam int HI_BIT = FIRST_BIT + NCH - 1;

  logic [NCH-1:0] data_hit;
  logic           en_hit, clr_hit, any_hit;
  logic [NCH-1:0] flags;
  logic [NCH-1:0] en_q;
  logic [NCH-1:0] ack_bits;
  logic [DW-1:0]  words [NCH];
  logic           fire_vec_any;

  mbx_fast_decode #(.NCH(NCH)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .data_hit(data_hit),
    .en_hit(en_hit), .clr_hit(clr_hit), .any_hit(any_hit)
  );

  assign ack_bits = clr_hit ? wr_data[FIRST_BIT +: NCH] : '0;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    mbx_fast_chan #(.DW(DW)) u_ch (
      .clk(clk), .rst_n(rst_n), .load(data_hit[g]), .ack(ack_bits[g]),
      .wdata(wr_data), .word(words[g]), .pending(flags[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      en_q <= '0;
    else if (en_hit) en_q <= wr_data[FIRST_BIT +: NCH];
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == EN_ADDR)   rd_data = spread_bits(en_q);
    if (rd_addr == STAT_ADDR) rd_data = spread_bits(flags);
    for (int i = 0; i < NCH; i++)
      if (rd_addr == chan_addr(i)) rd_data = words[i];
  end

  assign fire_vec_any = |(flags & en_q);
  assign irq = fire_vec_any;

  // R9: a write lands on at most one channel
  p_one_channel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(data_hit));
  // R7: the interrupt can only rise after a write of data or enable
  p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(wr_en));
  // R8: an unmapped or status-address write changes nothing
  p_ignored_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !any_hit) |=> ($stable(flags) && $stable(en_q)));
  // R1: state is clear in the cycle after reset
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(!rst_n) |-> (flags == '0 && en_q == '0 && !irq));

  initial begin
    assert (HI_BIT < DW) else $error("status field does not fit word");
  end
endmodule

// File: tb/sim_mbx_fast_top.sv
module sim_mbx_fast_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] m_word [NCH];
  logic [7:0]  m_stat;
  logic [7:0]  m_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbx_fast_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  function automatic logic [7:0] data_adr(input int i);
    return 8'h8C + 8'(i * 4);
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] a);
    if (a == 8'hC0) return {15'd0, m_en, 9'd0};
    if (a == 8'hC8) return {15'd0, m_stat, 9'd0};
    for (int i = 0; i < NCH; i++)
      if (a == data_adr(i)) return m_word[i];
    return 32'd0;
  endfunction

  function automatic logic model_irq();
    return |(m_stat & m_en);
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [31:0] d);
    if (a == 8'hC0) m_en = d[16:9];
    else if (a == 8'hC4) m_stat = m_stat & ~d[16:9];
    else
      for (int i = 0; i < NCH; i++)
        if (a == data_adr(i)) begin
          m_word[i] = d;
          m_stat[i] = 1'b1;
        end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic chk_rd(input logic [7:0] a, input string req);
    logic [31:0] e;
    rd_addr = a;
    #1;
    e = model_read(a);
    n_chk++;
    if (rd_data !== e) begin
      n_fail++;
      $display("FAIL %s addr %h: got %h expected %h", req, a, rd_data, e);
    end
  endtask

  task automatic chk_irq(input string req);
    #1;
    n_chk++;
    if (irq !== model_irq()) begin
      n_fail++;
      $display("FAIL %s irq: got %b expected %b", req, irq, model_irq());
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0]  a;
    logic [31:0] d;
    int          sel;
    void'($urandom(32'h5EED_0F17));
    for (int i = 0; i < NCH; i++) m_word[i] = '0;
    m_stat = '0; m_en = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk_rd(8'hC8, "R1"); chk_rd(8'hC0, "R1");
    chk_rd(data_adr(0), "R1"); chk_rd(data_adr(7), "R1"); chk_irq("R1");

    // R2 R3: channel 0 word and flag; disabled so no irq (R7)
    wr(data_adr(0), 32'hDEAD_BEEF);
    chk_rd(data_adr(0), "R2"); chk_rd(8'hC8, "R3"); chk_irq("R7");
    // R9 neighbours untouched
    chk_rd(data_adr(1), "R9");
    // R6 enable reg masks non-channel bits
    wr(8'hC0, 32'hFFFF_FFFF);
    chk_rd(8'hC0, "R6"); chk_irq("R7");
    // R4 zeros in clear leave flags
    wr(8'hC4, 32'hFFFE_01FF);
    chk_rd(8'hC8, "R4"); chk_irq("R7");
    chk_rd(8'hC4, "R4");
    // R4 clear bit 9; word kept
    wr(8'hC4, 32'h0000_0200);
    chk_rd(8'hC8, "R4"); chk_rd(data_adr(0), "R4"); chk_irq("R7");
    // R5 overwrite channel 7 twice
    wr(data_adr(7), 32'h1111_1111);
    wr(data_adr(7), 32'h2222_2222);
    chk_rd(data_adr(7), "R5"); chk_rd(8'hC8, "R5"); chk_irq("R7");
    // R8 status write and unmapped write ignored
    wr(8'hC8, 32'hFFFF_FFFF);
    chk_rd(8'hC8, "R8");
    wr(8'h90 + 8'h40, 32'hFFFF_FFFF);
    wr(8'h8D, 32'h5555_5555);
    chk_rd(8'hC8, "R8"); chk_rd(data_adr(0), "R8"); chk_rd(8'h10, "R8");
    chk_rd(8'h8D, "R8");
    // R7 only channel 3 enabled, channel 7 pending
    wr(8'hC0, 32'h0000_1000);
    chk_irq("R7");

    // random mix
    for (int k = 0; k < 600; k++) begin
      sel = int'($urandom_range(0, 9));
      d = $urandom;
      if (sel < 5) a = data_adr(int'($urandom_range(0, NCH - 1)));
      else if (sel < 7) a = 8'hC4;
      else if (sel == 7) a = 8'hC0;
      else if (sel == 8) a = 8'hC8;
      else a = 8'($urandom);
      wr(a, d);
      chk_irq("R7");
      chk_rd(8'hC8, "R3");
      chk_rd(data_adr(int'($urandom_range(0, NCH - 1))), "R9");
      chk_rd(8'($urandom), "R8");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule